// File: doc/BRIEF.md
# Serially Loaded PWM DAC Core

This block produces the switching waveform for a precision pulse-width-modulated digital-to-analog converter. A free-running counter of `CODE_W` bits sets the period, which is 2^CODE_W clock cycles. The counter is assembled from cascaded `STAGE_W`-bit stages. Each cycle the counter is compared with a held setpoint code. The result is registered on the system clock and leaves the block as a true and complementary pair. The pair drives two external switches that steer a reference level and signal common into an analog filter. The filtered average equals the reference times code / 2^CODE_W. With the default 16-bit code and a 10 MHz clock, the period is 65536 cycles, about 152.59 Hz.

A host loads the setpoint over three slow wires: serial data, a shift clock and a store strobe. The block synchronises all three into the system clock domain. A shift register collects bits MSB first. On a store strobe its contents go to a staging register. A two-state loader machine then hands the staged code to the comparator at the next counter wrap, so every period carries a single duty. The states are `LD_IDLE`, with no staged code waiting, and `LD_ARMED`, with a staged code waiting for a wrap. IDLE moves to ARMED when a store edge is seen. ARMED moves to IDLE at a wrap with no store edge in the same cycle, and the staged code is transferred on that wrap. ARMED stays in ARMED on a store edge.

Top module: `pwm_dac_core`

## Requirements
- R1: After reset, `pwm_true` is 0 and `pwm_comp` is 1. With no code stored, the held code is 0 and the output stays low in every cycle.
- R2: The counter counts up by one each clock. It returns to 0 after reaching all ones, so each period is exactly 2^CODE_W cycles. The first period starts on the first clock edge after reset is released.
- R3: In each period, `pwm_true` is high for exactly as many cycles as the held code. Those high cycles are the first ones of the period: the output is high while the counter is below the code, delayed by one register.
- R4: A held code of 0 gives an output that is low in every cycle of the period.
- R5: The full-scale code (all ones) gives an output that is high in every cycle of the period except the last.
- R6: Each bit is taken from `ser_din` on a rising edge of `ser_sck`. The bits shift in MSB first, so the last bit shifted becomes bit 0 of the code.
- R7: Shifting bits in without a store strobe leaves the output duty unchanged.
- R8: A code stored partway through a period does not change that period. It takes effect from the first cycle of the next period.
- R9: `pwm_comp` is always the inverse of `pwm_true`.
- R10: If two stores happen within one period, the later one determines the next period's duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the counter and outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial setpoint data, MSB first |
| ser_sck | input | 1 | Shift clock; a rising edge takes one bit |
| ser_latch | input | 1 | Store strobe; a rising edge moves the shift register to staging |
| pwm_true | output | 1 | Registered PWM output |
| pwm_comp | output | 1 | Registered complement of `pwm_true` |

## Verification
The hardest case to reach from the ports is a store that lands in the middle of a period. The bench has to show that the running period keeps its old duty and that the next one switches. It must also show that two stores in one period resolve to the later value. The bench keeps its own cycle index aligned to reset release and starts the stimulus at a known period boundary. It then issues the strobe partway through that period, or shifts a full code, stores it, shifts one more bit and stores again. It does this fast enough that both stores fall before the wrap. The monitor then compares the high-cycle count and the first high index of each whole period against the expected items queued for it.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    // Loader state: whether a stored code is waiting for the next wrap.
    typedef enum logic [0:0] {
        LD_IDLE  = 1'b0,
        LD_ARMED = 1'b1
    } ld_state_e;

endpackage

// File: rtl/pwm_sync_vec.sv
module pwm_sync_vec #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int CODE_W  = 16,
    parameter int STAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [CODE_W-1:0] cnt_o,
    output logic              wrap_o
);

    localparam int N_ST = CODE_W / STAGE_W;

    logic [N_ST:0]      en;
    logic [CODE_W-1:0]  cnt_w;

    assign en[0] = 1'b1;

    for (genvar g = 0; g < N_ST; g++) begin : g_stage
        logic [STAGE_W-1:0] st;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st <= '0;
            end else if (en[g]) begin
                st <= st + 1'b1;
            end
        end

        assign en[g+1] = en[g] & (&st);
        assign cnt_w[g*STAGE_W +: STAGE_W] = st;
    end

    assign cnt_o  = cnt_w;
    assign wrap_o = en[N_ST];

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_o) |=> (cnt_o == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cnt_o) |=> (cnt_o == CODE_W'($past(cnt_o) + 1'b1))); // R2

endmodule

// File: rtl/pwm_code_loader.sv
module pwm_code_loader
    import pwm_dac_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_s,
    input  logic              sck_s,
    input  logic              latch_s,
    input  logic              wrap_i,
    output logic [CODE_W-1:0] code_o
);

    ld_state_e         state_q, state_nx;
    logic              sck_d, latch_d;
    logic              sck_rise, latch_rise;
    logic [CODE_W-1:0] shreg, staged, code_q;

    assign sck_rise   = sck_s & ~sck_d;
    assign latch_rise = latch_s & ~latch_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LD_IDLE:  if (latch_rise)            state_nx = LD_ARMED;
            LD_ARMED: if (wrap_i && !latch_rise) state_nx = LD_IDLE;
            default:                             state_nx = LD_IDLE;
        endcase
    end

    // Datapath driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            latch_d <= 1'b0;
            shreg   <= '0;
            staged  <= '0;
            code_q  <= '0;
        end else begin
            sck_d   <= sck_s;
            latch_d <= latch_s;
            if (sck_rise)   shreg  <= {shreg[CODE_W-2:0], din_s};
            if (latch_rise) staged <= shreg;
            if (state_q == LD_ARMED && wrap_i) code_q <= staged;
        end
    end

    assign code_o = code_q;

    AST_HOLD_UNTIL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(code_o)); // R8
    AST_SHIFT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_rise |=> $stable(staged)); // R7
    AST_IDLE_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_IDLE) |=> $stable(code_o)); // R8

endmodule

// File: rtl/pwm_dac_core.sv
module pwm_dac_core #(
    parameter int CODE_W      = 16,
    parameter int STAGE_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_din,
    input  logic ser_sck,
    input  logic ser_latch,
    output logic pwm_true,
    output logic pwm_comp
);

    logic [2:0]        sync_q;
    logic [CODE_W-1:0] cnt;
    logic              wrap;
    logic [CODE_W-1:0] code;
    logic              raw;

    pwm_sync_vec #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_latch, ser_sck, ser_din}),
        .q_o   (sync_q)
    );

    pwm_period_counter #(.CODE_W(CODE_W), .STAGE_W(STAGE_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    pwm_code_loader #(.CODE_W(CODE_W)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_s   (sync_q[0]),
        .sck_s   (sync_q[1]),
        .latch_s (sync_q[2]),
        .wrap_i  (wrap),
        .code_o  (code)
    );

    assign raw = (cnt < code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_true <= 1'b0;
            pwm_comp <= 1'b1;
        end else begin
            pwm_true <= raw;
            pwm_comp <= ~raw;
        end
    end

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_true != pwm_comp); // R9
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |=> !pwm_true); // R4
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((&code) && !(&cnt)) |=> pwm_true); // R5

endmodule

// File: tb/pwm_dac_core_tb_top.sv
module pwm_dac_core_tb_top;

    localparam int W = 6;
    localparam int P = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_din = 1'b0, ser_sck = 1'b0, ser_latch = 1'b0;
    logic pwm_true, pwm_comp;

    int vectors = 0, fails = 0;
    int per_no = 0, idx = 0, hi_cnt = 0, first_hi = -1, comp_err = 0;
    int q_per[$], q_hi[$], q_first[$];
    string q_tag[$];

    always #5 clk = ~clk;

    pwm_dac_core #(.CODE_W(W), .STAGE_W(3), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_sck(ser_sck),
        .ser_latch(ser_latch), .pwm_true(pwm_true), .pwm_comp(pwm_comp)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(int per, int code, string tag);
        q_per.push_back(per);
        q_hi.push_back(code);
        q_first.push_back(code > 0 ? 0 : -1);
        q_tag.push_back(tag);
    endtask

    task automatic shift_bits(int value, int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_din = value[i];
            tick(1);
            ser_sck = 1'b1;
            tick(2);
            ser_sck = 1'b0;
            tick(1);
        end
    endtask

    task automatic strobe();
        ser_latch = 1'b1;
        tick(2);
        ser_latch = 1'b0;
        tick(2);
    endtask

    task automatic wait_until(int p);
        while (per_no < p) @(per_no);
    endtask

    task automatic load_code(int code, string tag);
        int p;
        shift_bits(code, W);
        strobe();
        p = per_no;
        wait_until(p + 2);
        push_exp(per_no, code, tag);
        push_exp(per_no + 1, code, tag);
        wait_until(per_no + 2);
    endtask

    // Monitor: measure each whole period and pop its expected items.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pwm_true === pwm_comp) comp_err++;
            if (pwm_true === 1'b1) begin
                hi_cnt++;
                if (first_hi < 0) first_hi = idx;
            end
            if (idx == P - 1) begin
                while (q_per.size() > 0 && q_per[0] <= per_no) begin
                    int eh, ef;
                    string t;
                    void'(q_per.pop_front());
                    eh = q_hi.pop_front();
                    ef = q_first.pop_front();
                    t  = q_tag.pop_front();
                    vectors++;
                    if (hi_cnt != eh || first_hi != ef) begin
                        fails++;
                        $display("FAIL %s period %0d: hi=%0d first=%0d expected hi=%0d first=%0d",
                                 t, per_no, hi_cnt, first_hi, eh, ef);
                    end
                end
                hi_cnt = 0;
                first_hi = -1;
                idx = 0;
                per_no++;
            end else begin
                idx++;
            end
        end
    end

    initial begin
        int p;
        tick(3);
        vectors++;
        if (pwm_true !== 1'b0 || pwm_comp !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset: true=%b comp=%b expected true=0 comp=1", pwm_true, pwm_comp);
        end
        push_exp(0, 0, "R1");
        push_exp(1, 0, "R1");
        #1 rst_n = 1'b1;
        wait_until(2);

        load_code(1, "R2");
        load_code(32, "R3");
        load_code(63, "R5");
        load_code(0, "R4");
        load_code(42, "R6");
        load_code(21, "R6");

        // R7: shift a new code without storing it
        p = per_no;
        push_exp(p, 21, "R7");
        push_exp(p + 1, 21, "R7");
        push_exp(p + 2, 21, "R7");
        shift_bits(63, W);
        wait_until(p + 3);

        // R8: store partway through a period
        p = per_no;
        push_exp(p, 21, "R8");
        push_exp(p + 1, 63, "R8");
        tick(30);
        strobe();
        wait_until(p + 2);

        // R10: two stores within one period, the later one wins
        p = per_no;
        push_exp(p, 63, "R10");
        push_exp(p + 1, 10, "R10");
        shift_bits(5, W);
        strobe();
        shift_bits(0, 1);
        strobe();
        wait_until(p + 2);

        vectors++;
        if (comp_err != 0) begin
            fails++;
            $display("FAIL R9 complement: mismatched cycles=%0d expected 0", comp_err);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule